// File: doc/BRIEF.md
# Preset-Reload Divide-by-40,000 Counter

This block divides its clock by 40,000. A 16-bit synchronous count is built from a chain of 4-bit stages that share one clock. Stage 0 holds the least significant nibble. Each stage advances only when the enable is high and every stage below it sits at its all-ones value.

The chain does not compare the count against a limit and clear it. When the whole count reaches 0xFFFF, the next enabled edge loads a preset of 2^16 − 40,000 = 0x63C0. The natural 65,536-state cycle is therefore cut to exactly 40,000 states. A one-clock pulse marks the terminal state, and the carry into each stage boundary is brought out for inspection. The preset comes from the modulus parameter at elaboration.

Top module: `preset_divider`

## Requirements
- R1: While `rst_n` is low, a clock edge loads `count_o` with 0x63C0 (2^16 minus 40,000).
- R2: On an edge with `en` high and `count_o` not 0xFFFF, `count_o` increases by exactly one. Stage i holds bits [4i+3:4i], so bits [3:0] belong to stage 0.
- R3: On an edge with `en` high and `count_o` equal to 0xFFFF, `count_o` becomes 0x63C0 and does not become zero.
- R4: `pulse_o` is high exactly when `en` is high and `count_o` is 0xFFFF, so each terminal state gives a pulse one clock wide.
- R5: While `en` is low, `count_o` holds its value on every edge and `pulse_o` stays low, including at 0xFFFF.
- R6: With `en` held high after reset, the first pulse appears after 39,999 edges, and later pulses are 40,000 edges apart.
- R7: `stage_carry_o[i]` is high exactly when `en` is high and stages 0 through i are all at 0xF. Bit i belongs to stage i, and the top bit equals `pulse_o`.
- R8: Outside reset, `count_o` never falls below 0x63C0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all stages |
| rst_n | input | 1 | Synchronous active-low reset; loads the preset |
| en | input | 1 | Count enable; low freezes the chain |
| count_o | output | 16 | Full chained count |
| pulse_o | output | 1 | Divided output, high for the terminal state |
| stage_carry_o | output | 4 | Carry out of each stage, bit i for stage i |

## Verification
The bench targets the nibble boundary at 0x63CF. There, only the stage-0 carry may be high. A design that linked the stages wrongly would move the wrong nibble or set a higher carry. The bench holds the chain at 0xFFFF with the enable low. A design that gated the pulse or the reload incorrectly would emit a pulse or reload while frozen. The bench also checks the reload target and counts the edges between pulses. A design that wrapped to zero, or that loaded the preset one edge late, would give a period other than 40,000.

// File: rtl/preset_divider_pkg.sv
package preset_divider_pkg;

   // Value loaded at terminal count so that the chain spans MODULUS states.
   function automatic longint unsigned reload_value(input int unsigned width,
                                                    input longint unsigned modulus);
      return (64'd1 << width) - modulus;
   endfunction

endpackage

// File: rtl/preset_divider_stage.sv
module preset_divider_stage #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] q,
   output logic         at_max
);

   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= load_val;
      else if (load) q <= load_val;
      else if (step) q <= q + 1'b1;
   end

   assign at_max = (q == ALL_ONES);

endmodule

// File: rtl/preset_divider.sv
module preset_divider #(
   parameter int unsigned STAGE_W         = 4,
   parameter int unsigned NUM_STAGES      = 4,
   parameter int unsigned MODULUS         = 40000,
   parameter bit          CARRY_LOOKAHEAD = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          en,
   output logic [STAGE_W*NUM_STAGES-1:0] count_o,
   output logic                          pulse_o,
   output logic [NUM_STAGES-1:0]         stage_carry_o
);

   localparam int unsigned CNT_W = STAGE_W * NUM_STAGES;
   localparam logic [CNT_W-1:0] PRESET =
      CNT_W'(preset_divider_pkg::reload_value(CNT_W, 64'(MODULUS)));

   if (STAGE_W < 1 || NUM_STAGES < 1) begin : g_bad_shape
      $error("preset_divider: STAGE_W and NUM_STAGES must be at least 1");
   end
   if (CNT_W > 32) begin : g_bad_width
      $error("preset_divider: chain wider than 32 bits");
   end
   if (MODULUS < 2 || 64'(MODULUS) > (64'd1 << CNT_W)) begin : g_bad_mod
      $error("preset_divider: MODULUS out of range for chain width");
   end

   logic [NUM_STAGES-1:0] at_max;
   logic [NUM_STAGES-1:0] step;
   logic                  reload;

   assign reload = stage_carry_o[NUM_STAGES-1];

   for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
      // Enable of stage i: en and every lower stage at all ones.
      if (i == 0) begin : g_first
         assign step[i] = en;
      end else if (CARRY_LOOKAHEAD) begin : g_look
         assign step[i] = en & (&at_max[i-1:0]);
      end else begin : g_ripple
         assign step[i] = stage_carry_o[i-1];
      end

      assign stage_carry_o[i] = step[i] & at_max[i];

      preset_divider_stage #(.W(STAGE_W)) u_stage (
         .clk      (clk),
         .rst_n    (rst_n),
         .step     (step[i]),
         .load     (reload),
         .load_val (PRESET[i*STAGE_W +: STAGE_W]),
         .q        (count_o[i*STAGE_W +: STAGE_W]),
         .at_max   (at_max[i])
      );
   end

   assign pulse_o = reload;

endmodule

// File: rtl/preset_divider_checker.sv
module preset_divider_checker #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned NUM_STAGES = 4,
   parameter logic [CNT_W-1:0] PRESET = '0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  en,
   input logic [CNT_W-1:0]      count_o,
   input logic                  pulse_o,
   input logic [NUM_STAGES-1:0] stage_carry_o
);

   localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && count_o != TERM) |=> count_o == $past(count_o) + 1'b1); // R2

   AST_RELOAD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      (en && count_o == TERM) |=> count_o == PRESET); // R3

   AST_PULSE_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> (en && count_o == TERM)); // R4

   AST_PULSE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o); // R4

   AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(count_o)); // R5

   AST_NO_PULSE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !pulse_o); // R5

   AST_TOP_CARRY_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      stage_carry_o[NUM_STAGES-1] == pulse_o); // R7

   for (genvar i = 1; i < NUM_STAGES; i++) begin : g_carry_chain
      AST_CARRY_NEEDS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
         stage_carry_o[i] |-> stage_carry_o[i-1]); // R7
   end

   AST_NEVER_BELOW_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      count_o >= PRESET); // R8

endmodule

bind preset_divider preset_divider_checker #(
   .CNT_W      (CNT_W),
   .NUM_STAGES (NUM_STAGES),
   .PRESET     (PRESET)
) u_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .en            (en),
   .count_o       (count_o),
   .pulse_o       (pulse_o),
   .stage_carry_o (stage_carry_o)
);

// File: tb/preset_divider_tb_top.sv
module preset_divider_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] PRESET = 16'h63C0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [15:0] count_o;
   logic        pulse_o;
   logic [3:0]  stage_carry_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   preset_divider dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (en),
      .count_o       (count_o),
      .pulse_o       (pulse_o),
      .stage_carry_o (stage_carry_o)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Advance n edges, ending at the following falling edge.
   task automatic edges(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; en = 1'b1;
      edges(3);
      check("R1 count in reset", count_o, PRESET);
      en = 1'b0;
      edges(1);
      check("R1 pulse in reset", pulse_o, 0);
      rst_n = 1'b1;
      edges(2);
      check("R1 count after release, disabled", count_o, PRESET);
   endtask

   task automatic t_increment();
      en = 1'b1;
      edges(5);
      check("R2 count after 5 edges", count_o, 16'h63C5);
      edges(10);
      check("R2 count at nibble boundary", count_o, 16'h63CF);
      check("R7 carry at 0x63CF", stage_carry_o, 4'b0001);
      check("R4 no pulse at 0x63CF", pulse_o, 0);
      edges(1);
      check("R2 stage 1 advance to 0x63D0", count_o, 16'h63D0);
      check("R7 carry at 0x63D0", stage_carry_o, 4'b0000);
   endtask

   task automatic t_hold();
      en = 1'b0;
      edges(8);
      check("R5 count held", count_o, 16'h63D0);
      check("R5 pulse low while held", pulse_o, 0);
   endtask

   task automatic t_terminal();
      en = 1'b1;
      edges(16'hFFFF - 16'h63D0);
      check("R2 reach terminal", count_o, 16'hFFFF);
      check("R4 pulse at terminal", pulse_o, 1);
      check("R7 all carries at terminal", stage_carry_o, 4'b1111);
      en = 1'b0;
      #1;
      check("R5 pulse gated by en at terminal", pulse_o, 0);
      check("R7 carries gated by en", stage_carry_o, 4'b0000);
      edges(5);
      check("R5 terminal held while disabled", count_o, 16'hFFFF);
      en = 1'b1;
      #1;
      check("R4 pulse resumes with en", pulse_o, 1);
      edges(1);
      check("R3 reload to preset", count_o, PRESET);
      check("R4 pulse one clock wide", pulse_o, 0);
   endtask

   task automatic t_period();
      int n;
      logic [15:0] lowest;
      rst_n = 1'b0; en = 1'b1;
      edges(2);
      rst_n = 1'b1;
      n = 0; lowest = 16'hFFFF;
      while (!pulse_o && n < 70000) begin
         edges(1); n++;
         if (count_o < lowest) lowest = count_o;
      end
      check("R6 edges to first pulse", n, 39999);
      n = 0;
      do begin
         edges(1); n++;
         if (count_o < lowest) lowest = count_o;
      end while (!pulse_o && n < 70000);
      check("R6 pulse period", n, 40000);
      check("R8 lowest count seen", lowest, PRESET);
   endtask

   initial begin
      edges(1);
      t_reset();
      t_increment();
      t_hold();
      t_terminal();
      t_period();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule